// File: doc/BRIEF.md
# Flash-Clearable Static RAM

This block is a clocked, synthesizable model of an 8192-word by 8-bit static memory that can be wiped in bulk. Access is gated by two chip selects of opposite polarity, an active-low output enable and an active-low write enable. The shared data bus is split into a write-data input, a read-data output and a drive flag that marks when the bus would be actively driven. The decoded modes are clear, standby, output off, read and write.

Pulling the active-low clear input low overrides every other control and forces every word to read back as zero within two clock edges. The storage array itself is never swept. Instead, each word carries a valid bit, and the valid bits sit in two banks chosen by the top address bit. The first clear edge wipes the lower bank and the second wipes the upper bank. A word whose valid bit is off reads as zero, and a write sets that word's valid bit again.

Top module: `clr_sram`

## Requirements
- R1: After reset, drive_o and busy_o are 0, rdata_o is 0, and every address reads back as 0.
- R2: The part is selected only when ce_lo_ni is 0 and ce_hi_i is 1. In any other case it is in standby: drive_o is 0 after the next edge and write requests have no effect.
- R3: A read is selected with clr_ni=1, oe_ni=0 and we_ni=1, and busy_o must be 0. One edge after the read, drive_o is 1 and rdata_o holds the word last written to addr_i, or 0 if that word has not been written since the last reset or clear.
- R4: When the part is selected with oe_ni=1 and we_ni=1, drive_o is 0 after the edge and the stored contents are left unchanged.
- R5: When the part is selected with we_ni=0, clr_ni=1 and busy_o=0, wdata_i is stored at addr_i whatever the value of oe_ni, and drive_o is 0 after that edge.
- R6: While clr_ni is 0, every other input is ignored: no write takes place, drive_o is 0 after each edge, and busy_o is 1.
- R7: The clear finishes within two edges. Words with addr_i[12]=0 are cleared at the first edge where clr_ni is 0, and words with addr_i[12]=1 are cleared at the next edge. If clr_ni is low for only one edge, busy_o stays 1 for one more cycle and then falls.
- R8: While busy_o is 1 with clr_ni=1, write requests are ignored and a read returns drive_o=1 with rdata_o=0.
- R9: If clr_ni is held low for two or more edges, busy_o is 0 as soon as clr_ni returns high, and a write at the very next edge is stored.
- R10: If a chip select deasserts in the cycle that follows a write, drive_o stays 0 even while oe_ni is low.
- R11: rdata_o is 0 whenever drive_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_ni | input | 1 | Bulk clear, active low |
| ce_lo_ni | input | 1 | Chip select, active low |
| ce_hi_i | input | 1 | Chip select, active high |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write enable, active low |
| addr_i | input | 13 | Word address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data, zero when not driving |
| drive_o | output | 1 | Data bus driven (low means high impedance) |
| busy_o | output | 1 | Clear in progress |

## Verification
The bench first fills words in both address halves, then fires a one-edge clear pulse, tries to write in the cycle that is still busy, and reads everything back. A design that cleared only the lower bank would return stale upper words, and one that accepted the busy write would return 0x99 where zero is expected. A second test holds clear low for three edges and writes on the first edge after release. A design that restarts the sweep on every low edge would report busy and drop that write. The bench also watches the bus after writes, in output-off mode, and when a select drops just as write enable rises, because a design that decodes modes loosely would drive stale data in those cases.

// File: rtl/clr_sram_pkg.sv
package clr_sram_pkg;
  typedef enum logic [2:0] {
    MODE_CLEAR   = 3'd0,
    MODE_STANDBY = 3'd1,
    MODE_OUT_OFF = 3'd2,
    MODE_READ    = 3'd3,
    MODE_WRITE   = 3'd4
  } mode_e;

  typedef enum logic [1:0] {
    CS_IDLE = 2'd0,
    CS_HALF = 2'd1,
    CS_DONE = 2'd2
  } clr_state_e;
endpackage

// File: rtl/clr_sram_decode.sv
module clr_sram_decode
  import clr_sram_pkg::*;
(
  input  logic  clr_ni,
  input  logic  ce_lo_ni,
  input  logic  ce_hi_i,
  input  logic  oe_ni,
  input  logic  we_ni,
  output mode_e mode_o
);
  logic sel;
  assign sel = ~ce_lo_ni & ce_hi_i;

  always_comb begin
    if (!clr_ni)     mode_o = MODE_CLEAR;
    else if (!sel)   mode_o = MODE_STANDBY;
    else if (!we_ni) mode_o = MODE_WRITE;
    else if (!oe_ni) mode_o = MODE_READ;
    else             mode_o = MODE_OUT_OFF;
  end
endmodule

// File: rtl/clr_sram_clear_seq.sv
module clr_sram_clear_seq
  import clr_sram_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_ni,
  output logic [1:0] wipe_o,
  output logic       busy_o
);
  clr_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    wipe_o  = 2'b00;
    unique case (state_q)
      CS_IDLE: if (!clr_ni) begin
        wipe_o  = 2'b01;
        state_d = CS_HALF;
      end
      CS_HALF: begin
        wipe_o  = 2'b10;
        state_d = clr_ni ? CS_IDLE : CS_DONE;
      end
      CS_DONE: if (clr_ni) state_d = CS_IDLE;
      default: state_d = CS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= CS_IDLE;
    else         state_q <= state_d;
  end

  // pending upper-bank wipe keeps the block busy after a short pulse
  assign busy_o = ~clr_ni | (state_q == CS_HALF);
endmodule

// File: rtl/clr_sram_valid_bank.sv
module clr_sram_valid_bank #(
  parameter int unsigned WORDS = 4096,
  localparam int unsigned IDX_W = $clog2(WORDS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wipe_i,
  input  logic             set_i,
  input  logic [IDX_W-1:0] set_idx_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             rd_valid_o
);
  logic [WORDS-1:0] valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     valid_q <= '0;
    else if (wipe_i) valid_q <= '0;
    else if (set_i)  valid_q[set_idx_i] <= 1'b1;
  end

  assign rd_valid_o = valid_q[rd_idx_i];
endmodule

// File: rtl/clr_sram.sv
module clr_sram
  import clr_sram_pkg::*;
#(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned DEPTH = 1 << ADDR_W,
  localparam int unsigned BANK_WORDS = DEPTH / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_ni,
  input  logic              ce_lo_ni,
  input  logic              ce_hi_i,
  input  logic              oe_ni,
  input  logic              we_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              drive_o,
  output logic              busy_o
);
  mode_e       mode;
  logic [1:0]  wipe;
  logic [1:0]  bank_valid;
  logic        wr_en, rd_en, rd_valid;
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rdata_q;
  logic              drive_q;

  clr_sram_decode u_decode (
    .clr_ni  (clr_ni),
    .ce_lo_ni(ce_lo_ni),
    .ce_hi_i (ce_hi_i),
    .oe_ni   (oe_ni),
    .we_ni   (we_ni),
    .mode_o  (mode)
  );

  clr_sram_clear_seq u_clear_seq (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_ni(clr_ni),
    .wipe_o(wipe),
    .busy_o(busy_o)
  );

  assign wr_en = (mode == MODE_WRITE) & ~busy_o;
  assign rd_en = (mode == MODE_READ);

  for (genvar b = 0; b < 2; b++) begin : g_bank
    clr_sram_valid_bank #(.WORDS(BANK_WORDS)) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wipe_i    (wipe[b]),
      .set_i     (wr_en && (addr_i[ADDR_W-1] == 1'(b))),
      .set_idx_i (addr_i[ADDR_W-2:0]),
      .rd_idx_i  (addr_i[ADDR_W-2:0]),
      .rd_valid_o(bank_valid[b])
    );
  end

  // once the lower bank is wiped and writes are blocked, every live word is zero
  assign rd_valid = bank_valid[addr_i[ADDR_W-1]] & ~busy_o;

  always_ff @(posedge clk_i) begin
    if (wr_en) mem[addr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      drive_q <= 1'b0;
      rdata_q <= '0;
    end else begin
      drive_q <= rd_en;
      rdata_q <= (rd_en && rd_valid) ? mem[addr_i] : '0;
    end
  end

  assign rdata_o = rdata_q;
  assign drive_o = drive_q;
endmodule

// File: rtl/clr_sram_chk.sv
module clr_sram_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              clr_ni,
  input logic              ce_lo_ni,
  input logic              ce_hi_i,
  input logic              oe_ni,
  input logic              we_ni,
  input logic [DATA_W-1:0] rdata_o,
  input logic              drive_o,
  input logic              busy_o
);
  // R6
  clear_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_ni |=> !drive_o);

  // R6
  clear_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_ni |-> busy_o);

  // R2
  standby_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_lo_ni || !ce_hi_i) |=> !drive_o);

  // R5
  write_hiz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_lo_ni && ce_hi_i && !we_ni) |=> !drive_o);

  // R4
  out_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ce_lo_ni && ce_hi_i && oe_ni && we_ni) |=> !drive_o);

  // R3
  read_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ni && !ce_lo_ni && ce_hi_i && !oe_ni && we_ni) |=> drive_o);

  // R7
  clear_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && clr_ni) |=> !busy_o);

  // R11
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drive_o |-> (rdata_o == '0));
endmodule

bind clr_sram clr_sram_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/clr_sram_bench.sv
module clr_sram_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        clr_ni = 1'b1, ce_lo_ni = 1'b1, ce_hi_i = 1'b0;
  logic        oe_ni = 1'b1, we_ni = 1'b1;
  logic [12:0] addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic [7:0]  rdata_o;
  logic        drive_o, busy_o;

  int vec_cnt = 0;
  int err_cnt = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  clr_sram u_clr_sram (.*);

  task automatic check(input string tag, input int act, input int exp);
    vec_cnt++;
    if (act !== exp) begin
      err_cnt++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // apply controls at the falling edge, cross one rising edge, return at the next falling edge
  task automatic cyc(input logic clr, input logic cel, input logic ceh, input logic oe,
                     input logic we, input logic [12:0] a, input logic [7:0] d);
    clr_ni = clr; ce_lo_ni = cel; ce_hi_i = ceh; oe_ni = oe; we_ni = we;
    addr_i = a; wdata_i = d;
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic wr(input logic [12:0] a, input logic [7:0] d, input logic oe);
    cyc(1'b1, 1'b0, 1'b1, oe, 1'b0, a, d);
  endtask

  task automatic rd_chk(input string tag, input logic [12:0] a, input logic [7:0] exp);
    cyc(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, a, 8'h00);
    check({tag, " drive"}, int'(drive_o), 1);
    check({tag, " data"}, int'(rdata_o), int'(exp));
  endtask

  task automatic idle();
    cyc(1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 13'h0, 8'h00);
  endtask

  task automatic t_reset();
    check("R1 drive", int'(drive_o), 0);
    check("R1 busy", int'(busy_o), 0);
    check("R1 data", int'(rdata_o), 0);
    rd_chk("R1 low addr", 13'h0005, 8'h00);
    rd_chk("R1 high addr", 13'h1FFF, 8'h00);
  endtask

  task automatic t_read_write();
    wr(13'h0000, 8'hA5, 1'b1);
    check("R5 no drive after write", int'(drive_o), 0);
    wr(13'h1FFF, 8'h5A, 1'b0);
    check("R5 no drive with oe low", int'(drive_o), 0);
    check("R11 zero data", int'(rdata_o), 0);
    wr(13'h1000, 8'hFF, 1'b0);
    wr(13'h0FFF, 8'h01, 1'b1);
    rd_chk("R3 addr 0", 13'h0000, 8'hA5);
    rd_chk("R3 top addr", 13'h1FFF, 8'h5A);
    rd_chk("R3 upper first", 13'h1000, 8'hFF);
    rd_chk("R3 lower last", 13'h0FFF, 8'h01);
    wr(13'h0000, 8'h3C, 1'b1);
    rd_chk("R3 overwrite", 13'h0000, 8'h3C);
    idle();
  endtask

  task automatic t_standby();
    cyc(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 13'h0000, 8'h55);
    check("R2 ce_lo high no drive", int'(drive_o), 0);
    cyc(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 13'h0000, 8'h66);
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 13'h0000, 8'h00);
    check("R2 ce_hi low read no drive", int'(drive_o), 0);
    check("R11 standby data", int'(rdata_o), 0);
    rd_chk("R2 writes ignored", 13'h0000, 8'h3C);
    idle();
  endtask

  task automatic t_out_off();
    rd_chk("R4 pre read", 13'h1FFF, 8'h5A);
    cyc(1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 13'h1FFF, 8'h77);
    check("R4 drive", int'(drive_o), 0);
    check("R11 out off data", int'(rdata_o), 0);
    rd_chk("R4 contents kept", 13'h1FFF, 8'h5A);
    idle();
  endtask

  task automatic t_ce_release();
    wr(13'h0042, 8'h42, 1'b0);
    cyc(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 13'h0042, 8'h00);
    check("R10 ce_lo drop", int'(drive_o), 0);
    wr(13'h0043, 8'h43, 1'b0);
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 13'h0043, 8'h00);
    check("R10 ce_hi drop", int'(drive_o), 0);
    rd_chk("R10 data written", 13'h0042, 8'h42);
    idle();
  endtask

  task automatic t_clear_pulse();
    wr(13'h0007, 8'h11, 1'b1);
    wr(13'h1009, 8'h22, 1'b1);
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 13'h0007, 8'h77);
    check("R6 no drive in clear", int'(drive_o), 0);
    check("R7 busy after short pulse", int'(busy_o), 1);
    wr(13'h0009, 8'h99, 1'b1);
    check("R7 busy falls", int'(busy_o), 0);
    rd_chk("R7 lower cleared", 13'h0007, 8'h00);
    rd_chk("R7 upper cleared", 13'h1009, 8'h00);
    rd_chk("R8 busy write dropped", 13'h0009, 8'h00);
    rd_chk("R7 old word cleared", 13'h1FFF, 8'h00);
    wr(13'h1123, 8'hC3, 1'b1);
    cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 13'h0, 8'h0);
    rd_chk("R8 read while busy", 13'h1123, 8'h00);
    check("R8 busy done", int'(busy_o), 0);
    idle();
  endtask

  task automatic t_clear_hold();
    wr(13'h1ABC, 8'h9E, 1'b1);
    wr(13'h0ABC, 8'h9F, 1'b1);
    cyc(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 13'h1ABC, 8'h12);
    check("R6 busy while low", int'(busy_o), 1);
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 13'h1ABC, 8'h00);
    check("R6 read ignored", int'(drive_o), 0);
    cyc(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 13'h0ABC, 8'h34);
    clr_ni = 1'b1;
    #1;
    check("R9 not busy at release", int'(busy_o), 0);
    wr(13'h1ABC, 8'h3C, 1'b1);
    rd_chk("R9 write after release", 13'h1ABC, 8'h3C);
    rd_chk("R6 write during clear dropped", 13'h0ABC, 8'h00);
    idle();
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, err_cnt);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    err_cnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_read_write();
    t_standby();
    t_out_off();
    t_ce_release();
    t_clear_pulse();
    t_clear_hold();
    summary();
    $finish;
  end
endmodule